// File: doc/BRIEF.md
# Dual-Oscillator Power Mode Controller

This block is the clock and power mode controller of a small microcontroller that can run from either of two oscillators, A and B. It holds an enable bit for each oscillator and a clock-select bit, and it accepts idle and power-down requests. From these it drives the oscillator enable lines, the clock-select line to the clock multiplexer, and the gates for the CPU clock and the peripheral clock.

Software changes the oscillator setup and requests low-power modes with a single register write. The controller rejects any write that would leave the core without a running clock. In idle it stops only the CPU clock. In power-down it stops both oscillators. Because the enable and select bits survive power-down, a wake restarts the oscillator that was selected on entry. The CPU clock then stays off until that oscillator reports ready. A configuration bit outside the mode registers chooses the startup oscillator at reset.

Top module: `osc_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are the startup state. With `boot_sel_a`=1: A enabled, B disabled, `clk_sel`=1. With `boot_sel_a`=0: B enabled, A disabled, `clk_sel`=0. In both cases both clock gates are on and both mode flags are 0.
- R2: A write (`wr_en`=1) in run mode has these fields: `wr_data[4]` enables B, `wr_data[3]` enables A, `wr_data[2]` is the select bit (1 = A, 0 = B), `wr_data[1]` requests power-down and `wr_data[0]` requests idle. An accepted write updates the enables and the select from the next cycle on.
- R3: A write is ignored as a whole if it would disable both oscillators, or disable the oscillator its select bit names. Enables, select and mode then stay unchanged.
- R4: A write that changes the select bit is ignored as a whole unless the target oscillator is already enabled and its ready input is high.
- R5: An accepted write with the idle bit set enters idle on the next cycle. The idle flag is 1, the CPU gate is off, the peripheral gate is on, and the oscillator outputs are unchanged.
- R6: Idle ends on `irq_any`, any `ext_irq` line or `kbd_irq`. On the next cycle the idle flag is 0, both gates are on, and the enables and select are unchanged.
- R7: An accepted write with the power-down bit set enters power-down on the next cycle. Both oscillator enables are 0, both gates are off and the power-down flag is 1.
- R8: In power-down, `irq_any` alone has no effect.
- R9: In power-down, any `ext_irq` line or `kbd_irq` clears the power-down flag on the next cycle. It also restores the stored oscillator enables, with both gates kept off. Both gates turn on in the cycle after the selected oscillator's ready input is seen high.
- R10: A write that sets both the idle bit and the power-down bit enters power-down.
- R11: Writes made in idle, in power-down or while waiting for ready are ignored.
- R12: Reset returns the block to the R1 state from any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_sel_a | input | 1 | Startup oscillator choice applied at reset (1 = A) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Write fields as listed in R2 |
| irq_any | input | 1 | Any enabled interrupt pending |
| ext_irq | input | EXT_W | Enabled external interrupt lines |
| kbd_irq | input | 1 | Keyboard interrupt |
| rdy_a | input | 1 | Oscillator A ready |
| rdy_b | input | 1 | Oscillator B ready |
| osc_a_en | output | 1 | Enable to oscillator A |
| osc_b_en | output | 1 | Enable to oscillator B |
| clk_sel | output | 1 | Clock multiplexer select (1 = A) |
| cpu_clk_en | output | 1 | CPU clock gate |
| per_clk_en | output | 1 | Peripheral clock gate |
| idle_flag | output | 1 | Idle mode active |
| pd_flag | output | 1 | Power-down mode active |

## Verification
The bench builds the block with EXT_W=2. This lets it wake from power-down through each external line separately, and also through the keyboard line. It holds the ready input of the restarting oscillator low for several cycles, so the wait for ready can be observed. It also starts with that input already high, which gives the shortest wake.

// File: rtl/osc_pwr_pkg.sv
// Shared definitions for the dual-oscillator power mode controller.
// Assumes a 5-bit write word whose field positions are given below.
package osc_pwr_pkg;
    localparam int unsigned WR_W    = 5;
    localparam int unsigned F_IDLE  = 0;
    localparam int unsigned F_PD    = 1;
    localparam int unsigned F_SEL   = 2;
    localparam int unsigned F_EN_A  = 3;
    localparam int unsigned F_EN_B  = 4;
    localparam int unsigned N_OSC   = 2;

    typedef enum logic [1:0] {
        M_RUN  = 2'd0,
        M_IDLE = 2'd1,
        M_DOWN = 2'd2,
        M_WAKE = 2'd3
    } mode_t;

    typedef struct packed {
        logic en_b;
        logic en_a;
        logic sel;
    } osc_cfg_t;

    // True when at least one oscillator runs and the selected one is enabled.
    function automatic logic cfg_legal(input osc_cfg_t c);
        return (c.en_a | c.en_b) && (c.sel ? c.en_a : c.en_b);
    endfunction
endpackage

// File: rtl/osc_pwr_regs.sv
// Oscillator enable/select register with a legality filter.
// Assumes wr_run is already qualified by run mode. It computes whether a
// proposed write is acceptable and commits it only when it is.
module osc_pwr_regs
    import osc_pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     boot_sel_a,
    input  logic     wr_run,
    input  osc_cfg_t wr_cfg,
    input  logic     rdy_a,
    input  logic     rdy_b,
    output osc_cfg_t cfg,
    output logic     accept
);
    logic sel_change;
    logic target_ok;

    // Decide whether the proposed configuration may be taken.
    always_comb begin
        sel_change = (wr_cfg.sel != cfg.sel);
        target_ok  = wr_cfg.sel ? (cfg.en_a & rdy_a) : (cfg.en_b & rdy_b);
        accept     = cfg_legal(wr_cfg) && (!sel_change || target_ok);
    end

    // Hold the configuration; load the startup choice on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= boot_sel_a ? osc_cfg_t'{en_b: 1'b0, en_a: 1'b1, sel: 1'b1}
                              : osc_cfg_t'{en_b: 1'b1, en_a: 1'b0, sel: 1'b0};
        end else if (wr_run && accept) begin
            cfg <= wr_cfg;
        end
    end
endmodule

// File: rtl/osc_pwr_fsm.sv
// Power mode sequencer: run, idle, power-down and wait-for-ready.
// Assumes accept is valid in the same cycle as wr_en. Power-down wins
// over idle when both are requested together.
module osc_pwr_fsm
    import osc_pwr_pkg::*;
#(
    parameter int unsigned EXT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             req_idle,
    input  logic             req_pd,
    input  logic             accept,
    input  logic             irq_any,
    input  logic [EXT_W-1:0] ext_irq,
    input  logic             kbd_irq,
    input  logic             sel_rdy,
    output mode_t            mode
);
    logic  pd_wake;
    mode_t mode_nx;

    // Compute the next mode from the current one and the wake sources.
    always_comb begin
        pd_wake = (|ext_irq) | kbd_irq;
        mode_nx = mode;
        unique case (mode)
            M_RUN: begin
                if (wr_en && accept) begin
                    if (req_pd)        mode_nx = M_DOWN;
                    else if (req_idle) mode_nx = M_IDLE;
                end
            end
            M_IDLE:  if (irq_any || pd_wake) mode_nx = M_RUN;
            M_DOWN:  if (pd_wake)            mode_nx = M_WAKE;
            M_WAKE:  if (sel_rdy)            mode_nx = M_RUN;
            default: mode_nx = M_RUN;
        endcase
    end

    // Register the mode; reset returns to run.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= M_RUN;
        else        mode <= mode_nx;
    end
endmodule

// File: rtl/osc_pwr_gates.sv
// Output decode from mode and stored configuration.
// Assumes cfg is always legal. Oscillators are forced off only in
// power-down; clock gates open only in run (CPU) or run/idle (peripherals).
module osc_pwr_gates
    import osc_pwr_pkg::*;
(
    input  mode_t            mode,
    input  osc_cfg_t         cfg,
    output logic [N_OSC-1:0] osc_en,
    output logic             clk_sel,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             idle_flag,
    output logic             pd_flag
);
    logic [N_OSC-1:0] cfg_en;
    assign cfg_en = {cfg.en_b, cfg.en_a};

    for (genvar i = 0; i < N_OSC; i++) begin : g_osc
        assign osc_en[i] = cfg_en[i] & (mode != M_DOWN);
    end

    // Drive select, gates and flags from the mode.
    always_comb begin
        clk_sel    = cfg.sel;
        cpu_clk_en = (mode == M_RUN);
        per_clk_en = (mode == M_RUN) || (mode == M_IDLE);
        idle_flag  = (mode == M_IDLE);
        pd_flag    = (mode == M_DOWN);
    end
endmodule

// File: rtl/osc_pwr_ctrl.sv
// Top of the dual-oscillator power mode controller.
// Assumes all inputs are synchronous to clk. Writes are taken only in run
// mode. The ready of the selected oscillator ends the wait after power-down.
module osc_pwr_ctrl
    import osc_pwr_pkg::*;
#(
    parameter int unsigned EXT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_sel_a,
    input  logic             wr_en,
    input  logic [WR_W-1:0]  wr_data,
    input  logic             irq_any,
    input  logic [EXT_W-1:0] ext_irq,
    input  logic             kbd_irq,
    input  logic             rdy_a,
    input  logic             rdy_b,
    output logic             osc_a_en,
    output logic             osc_b_en,
    output logic             clk_sel,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             idle_flag,
    output logic             pd_flag
);
    mode_t            mode;
    osc_cfg_t         cfg;
    osc_cfg_t         wr_cfg;
    logic             accept;
    logic             wr_run;
    logic             sel_rdy;
    logic [N_OSC-1:0] osc_en;

    // Unpack the write word and qualify writes and ready.
    always_comb begin
        wr_cfg.en_b = wr_data[F_EN_B];
        wr_cfg.en_a = wr_data[F_EN_A];
        wr_cfg.sel  = wr_data[F_SEL];
        wr_run      = wr_en && (mode == M_RUN);
        sel_rdy     = cfg.sel ? rdy_a : rdy_b;
    end

    osc_pwr_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_sel_a (boot_sel_a),
        .wr_run     (wr_run),
        .wr_cfg     (wr_cfg),
        .rdy_a      (rdy_a),
        .rdy_b      (rdy_b),
        .cfg        (cfg),
        .accept     (accept)
    );

    osc_pwr_fsm #(.EXT_W(EXT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .req_idle (wr_data[F_IDLE]),
        .req_pd   (wr_data[F_PD]),
        .accept   (accept),
        .irq_any  (irq_any),
        .ext_irq  (ext_irq),
        .kbd_irq  (kbd_irq),
        .sel_rdy  (sel_rdy),
        .mode     (mode)
    );

    osc_pwr_gates u_gates (
        .mode       (mode),
        .cfg        (cfg),
        .osc_en     (osc_en),
        .clk_sel    (clk_sel),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en),
        .idle_flag  (idle_flag),
        .pd_flag    (pd_flag)
    );

    assign osc_a_en = osc_en[0];
    assign osc_b_en = osc_en[1];
endmodule

// File: rtl/osc_pwr_ctrl_chk.sv
// Checker for osc_pwr_ctrl, observing only its ports; attached by bind.
module osc_pwr_ctrl_chk #(
    parameter int unsigned EXT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [EXT_W-1:0] ext_irq,
    input logic             kbd_irq,
    input logic             osc_a_en,
    input logic             osc_b_en,
    input logic             clk_sel,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             idle_flag,
    input logic             pd_flag
);
    // Outside power-down the selected oscillator is always enabled (R3).
    assert_sel_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_flag |-> (clk_sel ? osc_a_en : osc_b_en));

    // Idle stops the CPU clock but keeps peripherals clocked (R5).
    assert_idle_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idle_flag |-> (!cpu_clk_en && per_clk_en));

    // Oscillator setup is frozen while idle (R6).
    assert_idle_keeps_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idle_flag |=> $stable({osc_a_en, osc_b_en, clk_sel}));

    // Power-down stops both oscillators and both clocks (R7).
    assert_pd_all_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pd_flag |-> (!osc_a_en && !osc_b_en && !cpu_clk_en && !per_clk_en));

    // Without an external or keyboard wake, power-down persists (R8).
    assert_pd_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_flag && !(|ext_irq) && !kbd_irq) |=> pd_flag);

    // Leaving power-down never opens the CPU clock in the same cycle (R9).
    assert_wake_cpu_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pd_flag) && $past(rst_n)) |-> !cpu_clk_en);

    // Idle and power-down are never active together (R10).
    assert_modes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle_flag && pd_flag));
endmodule

bind osc_pwr_ctrl osc_pwr_ctrl_chk #(.EXT_W(EXT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_irq    (ext_irq),
    .kbd_irq    (kbd_irq),
    .osc_a_en   (osc_a_en),
    .osc_b_en   (osc_b_en),
    .clk_sel    (clk_sel),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .idle_flag  (idle_flag),
    .pd_flag    (pd_flag)
);

// File: tb/osc_pwr_ctrl_tb.sv
// Scoreboard bench: the driver queues expected output vectors; the monitor
// compares them on the falling edge after each rising edge.
// Vector order: {osc_a_en, osc_b_en, clk_sel, cpu_clk_en, per_clk_en, idle_flag, pd_flag}
// Write word: {en_b, en_a, sel, pd, idle}
module osc_pwr_ctrl_tb;
    localparam int unsigned EXT_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             boot_sel_a = 1'b1;
    logic             wr_en = 1'b0;
    logic [4:0]       wr_data = '0;
    logic             irq_any = 1'b0;
    logic [EXT_W-1:0] ext_irq = '0;
    logic             kbd_irq = 1'b0;
    logic             rdy_a = 1'b1;
    logic             rdy_b = 1'b0;
    logic             osc_a_en, osc_b_en, clk_sel, cpu_clk_en, per_clk_en, idle_flag, pd_flag;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string tag_q[$];
    logic [6:0] exp_q[$];

    always #2.5 clk = ~clk;

    osc_pwr_ctrl #(.EXT_W(EXT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .boot_sel_a(boot_sel_a),
        .wr_en(wr_en), .wr_data(wr_data), .irq_any(irq_any),
        .ext_irq(ext_irq), .kbd_irq(kbd_irq), .rdy_a(rdy_a), .rdy_b(rdy_b),
        .osc_a_en(osc_a_en), .osc_b_en(osc_b_en), .clk_sel(clk_sel),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .idle_flag(idle_flag), .pd_flag(pd_flag)
    );

    // Drive one cycle of stimulus and return just after the rising edge.
    task automatic tick(input logic w, input logic [4:0] d, input logic irq,
                        input logic [EXT_W-1:0] ex, input logic kb);
        @(negedge clk);
        wr_en = w; wr_data = d; irq_any = irq; ext_irq = ex; kbd_irq = kb;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [6:0] v);
        tag_q.push_back(tag);
        exp_q.push_back(v);
    endtask

    // Monitor: compare queued expectations against the outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                string      t;
                logic [6:0] e;
                logic [6:0] got;
                t   = tag_q.pop_front();
                e   = exp_q.pop_front();
                got = {osc_a_en, osc_b_en, clk_sel, cpu_clk_en, per_clk_en, idle_flag, pd_flag};
                n_checks++;
                if (got !== e) begin
                    n_fail++;
                    $display("FAIL %s got %b exp %b", t, got, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog got timeout exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tick(0, 5'b00000, 0, 2'b00, 0);   expect_out("R1 reset boot A", 7'b1011100);
        rst_n = 1'b1;
        tick(1, 5'b00100, 0, 2'b00, 0);   expect_out("R3 both off ignored", 7'b1011100);
        tick(1, 5'b11100, 0, 2'b00, 0);   expect_out("R2 enable B", 7'b1111100);
        tick(1, 5'b11000, 0, 2'b00, 0);   expect_out("R4 select B not ready", 7'b1111100);
        rdy_b = 1'b1;
        tick(1, 5'b11000, 0, 2'b00, 0);   expect_out("R4 select B ready", 7'b1101100);
        tick(1, 5'b10000, 0, 2'b00, 0);   expect_out("R2 disable A", 7'b0101100);
        tick(1, 5'b01000, 0, 2'b00, 0);   expect_out("R3 selected off ignored", 7'b0101100);
        tick(1, 5'b10001, 0, 2'b00, 0);   expect_out("R5 enter idle", 7'b0100110);
        tick(1, 5'b11100, 0, 2'b00, 0);   expect_out("R11 write in idle", 7'b0100110);
        tick(0, 5'b00000, 1, 2'b00, 0);   expect_out("R6 idle exit irq", 7'b0101100);
        tick(1, 5'b10010, 0, 2'b00, 0);   expect_out("R7 enter power-down", 7'b0000001);
        tick(0, 5'b00000, 1, 2'b00, 0);   expect_out("R8 irq_any in pd", 7'b0000001);
        tick(1, 5'b11100, 0, 2'b00, 0);   expect_out("R11 write in pd", 7'b0000001);
        rdy_b = 1'b0;
        tick(0, 5'b00000, 0, 2'b00, 1);   expect_out("R9 kbd wake restart B", 7'b0100000);
        tick(0, 5'b00000, 0, 2'b00, 0);   expect_out("R9 wait ready", 7'b0100000);
        tick(1, 5'b11100, 0, 2'b00, 0);   expect_out("R11 write while waiting", 7'b0100000);
        rdy_b = 1'b1;
        tick(0, 5'b00000, 0, 2'b00, 0);   expect_out("R9 ready seen", 7'b0101100);
        tick(1, 5'b10011, 0, 2'b00, 0);   expect_out("R10 idle+pd", 7'b0000001);
        tick(0, 5'b00000, 0, 2'b10, 0);   expect_out("R9 ext1 wake", 7'b0100000);
        tick(0, 5'b00000, 0, 2'b00, 0);   expect_out("R9 run after ready", 7'b0101100);
        tick(1, 5'b10001, 0, 2'b00, 0);   expect_out("R5 idle on B", 7'b0100110);
        rst_n = 1'b0; boot_sel_a = 1'b0;
        tick(0, 5'b00000, 0, 2'b00, 0);   expect_out("R12 reset from idle boot B", 7'b0101100);
        boot_sel_a = 1'b1;
        tick(0, 5'b00000, 0, 2'b00, 0);   expect_out("R1 reset boot A", 7'b1011100);
        rst_n = 1'b1;
        tick(1, 5'b01110, 0, 2'b00, 0);   expect_out("R7 pd on A", 7'b0010001);
        tick(0, 5'b00000, 0, 2'b01, 0);   expect_out("R9 ext0 wake A", 7'b1010000);
        tick(0, 5'b00000, 0, 2'b00, 0);   expect_out("R9 A ready run", 7'b1011100);
        tick(1, 5'b01101, 0, 2'b00, 0);   expect_out("R5 idle on A", 7'b1010110);
        tick(0, 5'b00000, 0, 2'b00, 1);   expect_out("R6 idle exit kbd", 7'b1011100);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule